// File: doc/BRIEF.md
# Configuration Cycle Bridge Forwarder

This block sits on the upstream side of a bus-to-bus bridge and decides what happens to each configuration request that reaches it. Three programmable bus numbers describe the bridge's position in the tree. The upstream number is the bus closest to the processor. The near-side downstream number is the bus attached directly below the bridge. The far-limit number is the highest bus that can be reached anywhere beneath it.

Each accepted request is sorted into one of three outcomes. It can be dropped. It can be passed downstream untouched as a bus-numbered (Type 1) request. Or it can be rewritten into a local (Type 0) request for the attached bus, with a device-select field in one of two encodings: one-hot or binary. One cycle after a request is accepted, the block reports whether it claimed the request. A claimed request is held on a ready/valid downstream port until it is taken.

Top module: `cfg_fwd_bridge`

## Requirements
- R1: After reset, all three bus numbers and the encoding bit are zero, `dn_valid` and `dec_valid` are low, and `up_ready` is high. With those values, a Type 1 request for bus 0 is rewritten and a Type 1 request for any other bus is dropped.
- R2: A request accepted with `up_type1`=0 (Type 0) is always dropped.
- R3: In a Type 1 address, the bus number sits in bits 23:16, the device in 15:11, the function in 10:8 and the register in 7:2. A Type 1 request whose bus equals the near-side number is rewritten to Type 0 (`dn_type1`=0). Its bits 10:2 are copied from the request and bits 1:0 are 00.
- R4: With the encoding bit at 0 (one-hot), the rewritten address has exactly one bit set in 31:11, at bit 11+device. A device above 20 has no such bit, so that request is dropped.
- R5: With the encoding bit at 1 (binary), the rewritten address carries the device number in bits 15:11 and zeros in bits 31:16.
- R6: A Type 1 request whose bus is above the near-side number and at or below the far-limit number is passed downstream with `dn_type1`=1 and all 32 address bits unchanged.
- R7: A Type 1 request whose bus is below the near-side number or above the far-limit number is dropped.
- R8: A Type 1 request whose bus equals the upstream number, but not the near-side number, is dropped even when it lies inside the forwarding range.
- R9: A request is accepted on a rising edge where `up_valid` and `up_ready` are both high. In the following cycle `dec_valid` is high for exactly one cycle and `dec_claim` gives the outcome (1 = rewritten or passed). `dec_valid` is low in every other cycle.
- R10: While `dn_valid` is high and `dn_ready` is low, `dn_addr`, `dn_type1` and `dn_valid` hold, and `up_ready` is low.
- R11: On a clock edge where `wr_en` is high, `wr_sel` picks the target: 0 upstream, 1 near-side, 2 far-limit, 3 encoding bit (taken from `wr_data` bit 0). Requests accepted on later edges use the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 upstream, 1 near-side, 2 far-limit, 3 encoding) |
| wr_data | input | 8 | Register write value |
| up_valid | input | 1 | Incoming configuration request valid |
| up_ready | output | 1 | Block can accept a request this cycle |
| up_addr | input | 32 | Incoming configuration address |
| up_type1 | input | 1 | 1 = bus-numbered (Type 1) request, 0 = local (Type 0) |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream side takes the request |
| dn_addr | output | 32 | Downstream address (rewritten or unchanged) |
| dn_type1 | output | 1 | 1 = passed as Type 1, 0 = rewritten to Type 0 |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_claim | output | 1 | Decision: 1 claimed, 0 dropped |

## Verification
A wrong bus number or encoding bit in the register stage shows up at the ports on the first request that crosses a range boundary. Its `dec_claim` and `dn_type1` appear one cycle after acceptance, so the bench sweeps every bus number around the near-side, far-limit and upstream values in both encodings. A wrong rewrite appears in `dn_addr` in that same cycle as a displaced select bit or damaged low bits. A fault in the holding stage shows only while the downstream side is stalled, as a changing `dn_addr` or an `up_ready` that stays high during the stall.

// File: rtl/cfg_fwd_pkg.sv
package cfg_fwd_pkg;
  typedef enum logic [1:0] {
    ACT_DROP  = 2'd0,
    ACT_PASS  = 2'd1,
    ACT_XLATE = 2'd2
  } act_e;

  typedef enum logic [1:0] {
    SEL_UPSTRM = 2'd0,
    SEL_NEAR   = 2'd1,
    SEL_FAR    = 2'd2,
    SEL_ENC    = 2'd3
  } sel_e;
endpackage

// File: rtl/cfg_bus_regs.sv
module cfg_bus_regs
  import cfg_fwd_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [BUS_W-1:0] wr_data,
  output logic [BUS_W-1:0] upstrm_num,
  output logic [BUS_W-1:0] near_num,
  output logic [BUS_W-1:0] far_num,
  output logic             enc_bin
);
  logic enc_write;
  assign enc_write = wr_en && (sel_e'(wr_sel) == SEL_ENC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upstrm_num <= '0;
      near_num   <= '0;
      far_num    <= '0;
      enc_bin    <= 1'b0;
    end else if (wr_en) begin
      case (sel_e'(wr_sel))
        SEL_UPSTRM: upstrm_num <= wr_data;
        SEL_NEAR:   near_num   <= wr_data;
        SEL_FAR:    far_num    <= wr_data;
        default:    enc_bin    <= wr_data[0];
      endcase
    end
  end

  // R11: the encoding bit moves only on a write aimed at it
  assert_enc_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !enc_write |=> $stable(enc_bin));
endmodule

// File: rtl/cfg_route_dec.sv
module cfg_route_dec
  import cfg_fwd_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             is_t1,
  input  logic [BUS_W-1:0] bus,
  input  logic [BUS_W-1:0] upstrm_num,
  input  logic [BUS_W-1:0] near_num,
  input  logic [BUS_W-1:0] far_num,
  input  logic             sel_fits,
  output act_e             act
);
  function automatic act_e classify(input logic t1,
                                    input logic [BUS_W-1:0] b,
                                    input logic [BUS_W-1:0] p,
                                    input logic [BUS_W-1:0] s,
                                    input logic [BUS_W-1:0] u,
                                    input logic fits);
    if (!t1)                return ACT_DROP;
    if (b == s)             return fits ? ACT_XLATE : ACT_DROP;
    if (b == p)             return ACT_DROP;
    if (b > s && b <= u)    return ACT_PASS;
    return ACT_DROP;
  endfunction

  assign act = classify(is_t1, bus, upstrm_num, near_num, far_num, sel_fits);
endmodule

// File: rtl/cfg_addr_xlate.sv
module cfg_addr_xlate #(
  parameter int ADDR_W  = 32,
  parameter int DEV_LSB = 11,
  parameter int DEV_W   = 5
) (
  input  logic [DEV_W-1:0]     dev,
  input  logic [DEV_LSB-3:0]   low_in,
  input  logic                 enc_bin,
  output logic [ADDR_W-1:0]    t0_addr,
  output logic                 sel_fits
);
  localparam int SEL_W = ADDR_W - DEV_LSB;

  logic [SEL_W-1:0] sel_hot;
  logic [SEL_W-1:0] sel_num;

  for (genvar i = 0; i < SEL_W; i++) begin : g_hot
    assign sel_hot[i] = (int'(dev) == i);
  end

  function automatic logic [SEL_W-1:0] bin_field(input logic [DEV_W-1:0] d);
    return SEL_W'(d);
  endfunction

  assign sel_num  = bin_field(dev);
  assign sel_fits = enc_bin || (int'(dev) < SEL_W);
  assign t0_addr  = {(enc_bin ? sel_num : sel_hot), low_in, 2'b00};
endmodule

// File: rtl/cfg_fwd_bridge.sv
module cfg_fwd_bridge
  import cfg_fwd_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int BUS_W   = 8,
  parameter int BUS_LSB = 16,
  parameter int DEV_LSB = 11,
  parameter int DEV_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_type1,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [ADDR_W-1:0] dn_addr,
  output logic              dn_type1,
  output logic              dec_valid,
  output logic              dec_claim
);
  logic [BUS_W-1:0]  upstrm_num, near_num, far_num;
  logic              enc_bin;
  logic [BUS_W-1:0]  req_bus;
  logic [DEV_W-1:0]  req_dev;
  logic [ADDR_W-1:0] t0_addr;
  logic              sel_fits;
  act_e              act;
  logic              accept;
  logic              claim_now;
  logic              dn_enc_bin;

  assign req_bus = up_addr[BUS_LSB +: BUS_W];
  assign req_dev = up_addr[DEV_LSB +: DEV_W];

  cfg_bus_regs #(.BUS_W(BUS_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .upstrm_num(upstrm_num), .near_num(near_num), .far_num(far_num), .enc_bin(enc_bin)
  );

  cfg_addr_xlate #(.ADDR_W(ADDR_W), .DEV_LSB(DEV_LSB), .DEV_W(DEV_W)) xlate_i (
    .dev(req_dev), .low_in(up_addr[DEV_LSB-1:2]), .enc_bin(enc_bin),
    .t0_addr(t0_addr), .sel_fits(sel_fits)
  );

  cfg_route_dec #(.BUS_W(BUS_W)) route_i (
    .is_t1(up_type1), .bus(req_bus), .upstrm_num(upstrm_num), .near_num(near_num),
    .far_num(far_num), .sel_fits(sel_fits), .act(act)
  );

  assign up_ready  = !dn_valid || dn_ready;
  assign accept    = up_valid && up_ready;
  assign claim_now = (act != ACT_DROP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_claim  <= 1'b0;
      dn_valid   <= 1'b0;
      dn_addr    <= '0;
      dn_type1   <= 1'b0;
      dn_enc_bin <= 1'b0;
    end else begin
      dec_valid <= accept;
      if (accept) begin
        dec_claim <= claim_now;
        dn_valid  <= claim_now;
        if (claim_now) begin
          dn_addr    <= (act == ACT_XLATE) ? t0_addr : up_addr;
          dn_type1   <= (act == ACT_PASS);
          dn_enc_bin <= enc_bin;
        end
      end else if (dn_ready) begin
        dn_valid <= 1'b0;
      end
    end
  end

  // R10: a stalled downstream request holds still
  assert_dn_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr) && $stable(dn_type1)));

  // R2: a local request never produces a claim
  assert_t0_dropped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !up_type1) |=> (dec_valid && !dec_claim));

  // R9: decision strobe follows acceptance by exactly one cycle
  assert_dec_timing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> dec_valid);
  assert_dec_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !dec_valid);

  // R3: rewritten requests end in 00
  assert_t0_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_type1) |-> (dn_addr[1:0] == 2'b00));

  // R4: one-hot rewrite selects exactly one device line
  assert_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_type1 && !dn_enc_bin) |-> ($countones(dn_addr[ADDR_W-1:DEV_LSB]) == 1));

  // R10: no acceptance while a stalled request is pending
  assert_stall_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |-> !up_ready);
endmodule

// File: tb/cfg_fwd_bridge_tb.sv
module cfg_fwd_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [7:0]  wr_data;
  logic        up_valid;
  logic        up_ready;
  logic [31:0] up_addr;
  logic        up_type1;
  logic        dn_valid;
  logic        dn_ready;
  logic [31:0] dn_addr;
  logic        dn_type1;
  logic        dec_valid;
  logic        dec_claim;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int m_up, m_near, m_far, m_bin;

  always #5 clk = ~clk;

  cfg_fwd_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .up_valid(up_valid), .up_ready(up_ready), .up_addr(up_addr), .up_type1(up_type1),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr), .dn_type1(dn_type1),
    .dec_valid(dec_valid), .dec_claim(dec_claim)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel[1:0]; wr_data = val[7:0];
    @(negedge clk);
    wr_en = 1'b0;
    case (sel)
      0: m_up = val;
      1: m_near = val;
      2: m_far = val;
      default: m_bin = val & 1;
    endcase
  endtask

  function automatic logic [31:0] mk(input int top, input int bus, input int dev,
                                     input int fn, input int rg, input int low);
    return 32'((top << 24) + (bus << 16) + (dev << 11) + (fn << 8) + (rg << 2) + low);
  endfunction

  // send one request and compare the decision one cycle later
  task automatic send(input string req, input bit t1, input int top, input int bus,
                      input int dev, input int fn, input int rg);
    logic [31:0] a;
    bit xl, ps, claim;
    logic [31:0] ea;
    a = mk(top, bus, dev, fn, rg, t1 ? 1 : 0);
    xl = t1 && (bus == m_near) && (m_bin == 1 || dev <= 20);
    ps = t1 && (bus != m_near) && (bus != m_up) && (bus > m_near) && (bus <= m_far);
    claim = xl || ps;
    if (m_bin == 1) ea = 32'(dev * 2048 + fn * 256 + rg * 4);
    else            ea = 32'((64'd1 << (11 + dev)) + fn * 256 + rg * 4);
    @(negedge clk);
    up_valid = 1'b1; up_addr = a; up_type1 = t1;
    @(posedge clk);
    #1;
    check({req, " dec_valid"}, 32'(dec_valid), 32'd1);
    check({req, " dec_claim"}, 32'(dec_claim), 32'(claim));
    check({req, " dn_valid"},  32'(dn_valid),  32'(claim));
    if (xl) begin
      check({req, " rewrite addr"}, dn_addr, ea);
      check({req, " rewrite type"}, 32'(dn_type1), 32'd0);
    end
    if (ps) begin
      check({req, " pass addr"}, dn_addr, a);
      check({req, " pass type"}, 32'(dn_type1), 32'd1);
    end
    @(negedge clk);
    up_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    int devs[5] = '{0, 1, 20, 21, 31};
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    up_valid = 1'b0; up_addr = '0; up_type1 = 1'b0; dn_ready = 1'b1;
    m_up = 0; m_near = 0; m_far = 0; m_bin = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: idle outputs in reset
    check("R1 reset dn_valid", 32'(dn_valid), 32'd0);
    check("R1 reset dec_valid", 32'(dec_valid), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 up_ready after reset", 32'(up_ready), 32'd1);
    // R1: zeroed numbers rewrite bus 0, drop others
    send("R1 bus0 after reset", 1'b1, 0, 0, 3, 2, 5);
    send("R1 bus1 after reset", 1'b1, 0, 1, 3, 2, 5);
    send("R1 bus255 after reset", 1'b1, 0, 255, 0, 0, 0);

    // R11 R6 R7 R8 R3 R4 R5: sweep buses around the programmed range
    wr(0, 1); wr(1, 3); wr(2, 6);
    for (int enc = 0; enc < 2; enc++) begin
      wr(3, enc);
      for (int b = 0; b <= 10; b++) begin
        for (int k = 0; k < 5; k++) begin
          send("R3/R4/R5/R6/R7 sweep", 1'b1, 8'hA5, b, devs[k], k, 13 + k);
        end
      end
    end

    // R2: local requests are dropped on every bus
    for (int b = 0; b <= 8; b++) send("R2 type0 dropped", 1'b0, 0, b, 2, 1, 1);

    // R8: upstream number inside the range blocks forwarding
    wr(3, 0); wr(0, 5);
    send("R8 upstream bus dropped", 1'b1, 0, 5, 1, 0, 0);
    send("R8 neighbour still passes", 1'b1, 0, 4, 1, 0, 0);
    wr(0, 3);
    send("R8 upstream equals near rewrites", 1'b1, 0, 3, 4, 7, 63);

    // R11: write seen by next request
    wr(1, 7); wr(2, 9);
    send("R11 new near rewrites", 1'b1, 0, 7, 0, 0, 1);
    send("R11 old near now dropped", 1'b1, 0, 3, 0, 0, 1);
    send("R11 new far passes", 1'b1, 0, 9, 0, 0, 1);

    // R10: stall behaviour
    @(negedge clk);
    dn_ready = 1'b0;
    send("R10 stalled claim", 1'b1, 0, 8, 2, 0, 0);
    held = dn_addr;
    @(negedge clk);
    up_valid = 1'b1; up_addr = mk(0, 7, 1, 0, 0, 1); up_type1 = 1'b1;
    for (int c = 0; c < 3; c++) begin
      #1;
      check("R10 up_ready low while stalled", 32'(up_ready), 32'd0);
      @(posedge clk);
      #1;
      check("R10 dn_valid held", 32'(dn_valid), 32'd1);
      check("R10 dn_addr held", dn_addr, held);
      check("R9 no strobe while stalled", 32'(dec_valid), 32'd0);
      @(negedge clk);
    end
    up_valid = 1'b0;
    dn_ready = 1'b1;
    @(posedge clk);
    #1;
    check("R10 released dn_valid", 32'(dn_valid), 32'd0);
    check("R9 no strobe without request", 32'(dec_valid), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule